// File: doc/BRIEF.md
# Typed Fragment Dispatch Unit

This block takes a stream of decoded code fragments and hands them to four worker execution slots. Each fragment is tagged with a category, a thread number, its own tag, the tag of a producer fragment and an iteration count. The payload word is opaque to the block. Worker-bound fragments are placed into one wait queue per category: free, loop and depend. Each cycle the queue heads are matched against the idle workers. Memory, special and register fragments never reach a worker. They go out one cycle later on a side channel.

A per-tag scoreboard counts the units of each fragment that have not finished. It is loaded when a fragment is accepted and counts down on each worker completion. A depend fragment waits on this scoreboard until its producer is fully complete. A loop fragment is issued one of two ways: one iteration per idle worker, or in gang mode as four parts, one part per cycle, to workers 0 to 3.

Top module: `frag_dispatch`

## Requirements
- R1: Kind encoding is memory 0, free 1, loop 2, depend 3, special 4, register 5. Memory, special and register fragments are always accepted. In the next cycle they appear on `side_valid_o`, on bit 0, 1 or 2 respectively, with their thread and payload, and they never issue to a worker.
- R2: The free, loop and depend queues each hold 8 entries. `in_ready_o` is low exactly when the queue of the presented kind is full. A fragment presented while ready is low is not taken.
- R3: Issues go to idle workers, lowest index first. A worker stays busy from its issue cycle until a `done_i` pulse. A `done_i` pulse on an idle worker has no effect.
- R4: No more than three workers are issued in any one cycle.
- R5: A depend fragment issues only when every unit of the fragment named by its producer tag has completed, that is, the scoreboard count for that tag is zero.
- R6: A non-gang loop runs iteration-field+1 iterations. Each iteration goes to its own idle worker. Iteration indices appear on `wk_iter_o` in ascending order, and several iterations may issue in one cycle. The loop leaves its queue when its last iteration issues.
- R7: A gang loop at the loop queue head stops all other issue until every worker is idle. Its parts 0 to 3 then go to workers 0 to 3, one per cycle, with the part number on `wk_iter_o`. No other fragment issues until all four parts have completed, plus one more cycle. The iteration field of a gang loop is ignored.
- R8: Within one cycle, idle workers are filled in this order: the depend head, then loop iterations, then the free head. A free fragment issues even while an older depend fragment is held.
- R9: During and just after reset, no worker or side output is valid, every worker is idle and `in_ready_o` is high.
- R10: Kinds 6 and 7 are accepted and discarded with no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input fragment valid |
| in_ready_o | output | 1 | Input fragment taken this cycle when valid |
| in_kind_i | input | 3 | Fragment category |
| in_tid_i | input | TID_W | Thread number |
| in_tag_i | input | TAG_W | Tag of this fragment |
| in_dep_i | input | TAG_W | Producer tag (depend kind) |
| in_iters_i | input | ITER_W | Iteration count minus one (loop kind) |
| in_gang_i | input | 1 | Loop is issued in gang mode |
| in_payload_i | input | PW | Opaque fragment body |
| done_i | input | 4 | Completion pulse per worker |
| wk_valid_o | output | 4 | One-cycle issue pulse per worker |
| wk_tid_o | output | 4 x TID_W | Thread of the issued fragment |
| wk_iter_o | output | 4 x ITER_W | Iteration or gang part index |
| wk_payload_o | output | 4 x PW | Payload of the issued fragment |
| side_valid_o | output | 3 | Side forward: bit0 memory, bit1 special, bit2 register |
| side_tid_o | output | TID_W | Thread of the forwarded fragment |
| side_payload_o | output | PW | Payload of the forwarded fragment |

## Verification
A behavioural model with plain queues and per-tag counters predicts every output on every cycle, across several input patterns. Side kinds and the two unused codes are sent back to back, which separates forwarding from queueing. A six-iteration loop on an idle machine shows the three-issue cap against a fourth idle worker. A depend fragment queued behind that loop, with a free fragment after it, separates held dependency from out-of-order free issue. A gang loop arrives while workers are busy and a free fragment is waiting; this shows the drain, the part ordering and the blocking tail. A burst of nine free fragments against busy workers hits the full-queue boundary, and stray completions on idle workers must leave the scoreboard unchanged.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int NW        = 4;
  localparam int MAX_ISSUE = 3;

  typedef enum logic [2:0] {
    K_MEM  = 3'd0,
    K_FREE = 3'd1,
    K_LOOP = 3'd2,
    K_DEP  = 3'd3,
    K_SPEC = 3'd4,
    K_REG  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DEP,
    SRC_LOOP,
    SRC_FREE,
    SRC_GANG
  } src_e;
endpackage

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + {{AW{1'b0}}, push_i} - {{AW{1'b0}}, pop_i};
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
endmodule

// File: rtl/frag_scoreboard.sv
module frag_scoreboard #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 5,
  parameter int NW    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_i,
  input  logic [TAG_W-1:0]           set_tag_i,
  input  logic [CNT_W-1:0]           set_cnt_i,
  input  logic [NW-1:0]              dec_i,
  input  logic [NW-1:0][TAG_W-1:0]   dec_tag_i,
  input  logic [TAG_W-1:0]           qry_tag_i,
  output logic                       qry_zero_o
);
  localparam int NT = 1 << TAG_W;

  logic [NT-1:0] zero_vec;

  for (genvar t = 0; t < NT; t++) begin : g_tag
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sub;

    always_comb begin
      sub = '0;
      for (int w = 0; w < NW; w++)
        if (dec_i[w] && dec_tag_i[w] == TAG_W'(t)) sub = sub + CNT_W'(1);
    end

    // a fresh load wins over completions of a stale user of the same tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 cnt_q <= '0;
      else if (set_i && set_tag_i == TAG_W'(t))    cnt_q <= set_cnt_i;
      else                                         cnt_q <= cnt_q - sub;
    end

    assign zero_vec[t] = (cnt_q == '0);
  end

  assign qry_zero_o = zero_vec[qry_tag_i];
endmodule

// File: rtl/frag_issue.sv
module frag_issue
  import frag_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [NW-1:0]    busy_i,
  input  logic             dep_ok_i,
  input  logic             lq_valid_i,
  input  logic             lq_gang_i,
  input  logic [CNT_W-1:0] lq_left_i,
  input  logic             fq_valid_i,
  input  logic             gang_on_i,
  input  logic [2:0]       gang_part_i,
  output src_e             src_o      [NW],
  output logic [CNT_W-1:0] loop_off_o [NW],
  output logic [CNT_W-1:0] loop_cnt_o,
  output logic             dep_take_o,
  output logic             free_take_o
);
  localparam int WI = $clog2(NW);

  logic [2:0] n;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      src_o[w]      = SRC_NONE;
      loop_off_o[w] = '0;
    end
    loop_cnt_o  = '0;
    dep_take_o  = 1'b0;
    free_take_o = 1'b0;
    n           = '0;
    if (gang_on_i) begin
      if (gang_part_i < 3'(NW)) src_o[gang_part_i[WI-1:0]] = SRC_GANG;
    end else if (lq_valid_i && lq_gang_i) begin
      // drain: nothing issues until the whole pool is idle
      if (busy_i == '0) src_o[0] = SRC_GANG;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (!busy_i[w] && n < 3'(MAX_ISSUE)) begin
          if (dep_ok_i && !dep_take_o) begin
            src_o[w]   = SRC_DEP;
            dep_take_o = 1'b1;
            n          = n + 3'd1;
          end else if (lq_valid_i && loop_cnt_o < lq_left_i) begin
            src_o[w]      = SRC_LOOP;
            loop_off_o[w] = loop_cnt_o;
            loop_cnt_o    = loop_cnt_o + CNT_W'(1);
            n             = n + 3'd1;
          end else if (fq_valid_i && !free_take_o) begin
            src_o[w]    = SRC_FREE;
            free_take_o = 1'b1;
            n           = n + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frag_dispatch.sv
module frag_dispatch
  import frag_pkg::*;
#(
  parameter int PW     = 16,
  parameter int TID_W  = 3,
  parameter int TAG_W  = 4,
  parameter int ITER_W = 4,
  parameter int QDEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [2:0]                   in_kind_i,
  input  logic [TID_W-1:0]             in_tid_i,
  input  logic [TAG_W-1:0]             in_tag_i,
  input  logic [TAG_W-1:0]             in_dep_i,
  input  logic [ITER_W-1:0]            in_iters_i,
  input  logic                         in_gang_i,
  input  logic [PW-1:0]                in_payload_i,
  input  logic [NW-1:0]                done_i,
  output logic [NW-1:0]                wk_valid_o,
  output logic [NW-1:0][TID_W-1:0]     wk_tid_o,
  output logic [NW-1:0][ITER_W-1:0]    wk_iter_o,
  output logic [NW-1:0][PW-1:0]        wk_payload_o,
  output logic [2:0]                   side_valid_o,
  output logic [TID_W-1:0]             side_tid_o,
  output logic [PW-1:0]                side_payload_o
);
  localparam int CNT_W  = ITER_W + 1;
  localparam int O_TID  = PW;
  localparam int O_TAG  = O_TID + TID_W;
  localparam int O_DEP  = O_TAG + TAG_W;
  localparam int O_IT   = O_DEP + TAG_W;
  localparam int O_GANG = O_IT + ITER_W;
  localparam int EW     = O_GANG + 1;
  localparam int NQ     = 3;
  localparam int QF = 0, QL = 1, QD = 2;

  // ---------------- input side ----------------
  logic          acc;
  logic [EW-1:0] in_ent;
  logic [NQ-1:0] q_push, q_pop, q_empty, q_full;
  logic [EW-1:0] q_head [NQ];

  assign in_ent = {in_gang_i, in_iters_i, in_dep_i, in_tag_i, in_tid_i, in_payload_i};

  always_comb begin
    case (in_kind_i)
      K_FREE:  in_ready_o = !q_full[QF];
      K_LOOP:  in_ready_o = !q_full[QL];
      K_DEP:   in_ready_o = !q_full[QD];
      default: in_ready_o = 1'b1;
    endcase
  end

  assign acc = in_valid_i && in_ready_o;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [2:0] QK = (q == QF) ? K_FREE : (q == QL) ? K_LOOP : K_DEP;
    assign q_push[q] = acc && (in_kind_i == QK);
    frag_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (q_push[q]),
      .pop_i   (q_pop[q]),
      .data_i  (in_ent),
      .data_o  (q_head[q]),
      .empty_o (q_empty[q]),
      .full_o  (q_full[q])
    );
  end

  // ---------------- queue heads ----------------
  logic [PW-1:0]     f_pay, l_pay, d_pay;
  logic [TID_W-1:0]  f_tid, l_tid, d_tid;
  logic [TAG_W-1:0]  f_tag, l_tag, d_tag, d_dep;
  logic [ITER_W-1:0] l_iters;
  logic              l_gang;

  assign f_pay   = q_head[QF][PW-1:0];
  assign f_tid   = q_head[QF][O_TID +: TID_W];
  assign f_tag   = q_head[QF][O_TAG +: TAG_W];
  assign l_pay   = q_head[QL][PW-1:0];
  assign l_tid   = q_head[QL][O_TID +: TID_W];
  assign l_tag   = q_head[QL][O_TAG +: TAG_W];
  assign l_iters = q_head[QL][O_IT +: ITER_W];
  assign l_gang  = q_head[QL][O_GANG];
  assign d_pay   = q_head[QD][PW-1:0];
  assign d_tid   = q_head[QD][O_TID +: TID_W];
  assign d_tag   = q_head[QD][O_TAG +: TAG_W];
  assign d_dep   = q_head[QD][O_DEP +: TAG_W];

  logic unused_fields;
  assign unused_fields = ^{q_head[QF][EW-1:O_DEP], q_head[QL][O_IT-1:O_DEP],
                           q_head[QD][EW-1:O_IT]};

  // ---------------- worker state ----------------
  logic [NW-1:0]            busy_q;
  logic [NW-1:0][TAG_W-1:0] wtag_q;
  logic [CNT_W-1:0]         lp_next_q;
  logic                     gang_on_q;
  logic [2:0]               gang_part_q;
  logic [NW-1:0]            dec;

  assign dec = done_i & busy_q;

  // ---------------- scoreboard ----------------
  logic             sb_zero;
  logic [CNT_W-1:0] set_cnt;

  always_comb begin
    if (in_kind_i == K_LOOP) set_cnt = in_gang_i ? CNT_W'(NW) : {1'b0, in_iters_i} + CNT_W'(1);
    else                     set_cnt = CNT_W'(1);
  end

  frag_scoreboard #(.TAG_W(TAG_W), .CNT_W(CNT_W), .NW(NW)) u_sb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (|q_push),
    .set_tag_i  (in_tag_i),
    .set_cnt_i  (set_cnt),
    .dec_i      (dec),
    .dec_tag_i  (wtag_q),
    .qry_tag_i  (d_dep),
    .qry_zero_o (sb_zero)
  );

  // ---------------- issue selection ----------------
  src_e             src      [NW];
  logic [CNT_W-1:0] loop_off [NW];
  logic [CNT_W-1:0] loop_cnt, lq_left;
  logic             dep_take, free_take;

  assign lq_left = {1'b0, l_iters} + CNT_W'(1) - lp_next_q;

  frag_issue #(.CNT_W(CNT_W)) u_issue (
    .busy_i      (busy_q),
    .dep_ok_i    (!q_empty[QD] && sb_zero),
    .lq_valid_i  (!q_empty[QL]),
    .lq_gang_i   (l_gang),
    .lq_left_i   (lq_left),
    .fq_valid_i  (!q_empty[QF]),
    .gang_on_i   (gang_on_q),
    .gang_part_i (gang_part_q),
    .src_o       (src),
    .loop_off_o  (loop_off),
    .loop_cnt_o  (loop_cnt),
    .dep_take_o  (dep_take),
    .free_take_o (free_take)
  );

  logic [NW-1:0][TAG_W-1:0] iss_tag;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      logic [CNT_W-1:0] it;
      it              = '0;
      wk_valid_o[w]   = (src[w] != SRC_NONE);
      wk_tid_o[w]     = '0;
      wk_payload_o[w] = '0;
      iss_tag[w]      = '0;
      case (src[w])
        SRC_DEP:  begin wk_tid_o[w] = d_tid; wk_payload_o[w] = d_pay; iss_tag[w] = d_tag; end
        SRC_FREE: begin wk_tid_o[w] = f_tid; wk_payload_o[w] = f_pay; iss_tag[w] = f_tag; end
        SRC_LOOP: begin
          wk_tid_o[w] = l_tid; wk_payload_o[w] = l_pay; iss_tag[w] = l_tag;
          it = lp_next_q + loop_off[w];
        end
        SRC_GANG: begin
          wk_tid_o[w] = l_tid; wk_payload_o[w] = l_pay; iss_tag[w] = l_tag;
          it = gang_on_q ? CNT_W'(gang_part_q) : '0;
        end
        default: ;
      endcase
      wk_iter_o[w] = it[ITER_W-1:0];
    end
  end

  // ---------------- pops and sequencing ----------------
  logic gang_start, gang_pop, loop_pop;

  assign gang_start = !gang_on_q && (src[0] == SRC_GANG);
  assign gang_pop   = gang_on_q && (gang_part_q == 3'(NW-1));
  assign loop_pop   = gang_pop ||
                      (!gang_on_q && (loop_cnt != '0) && (loop_cnt == lq_left));
  assign q_pop[QF]  = free_take;
  assign q_pop[QD]  = dep_take;
  assign q_pop[QL]  = loop_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= '0;
      wtag_q      <= '0;
      lp_next_q   <= '0;
      gang_on_q   <= 1'b0;
      gang_part_q <= '0;
    end else begin
      busy_q <= (busy_q & ~dec) | wk_valid_o;
      for (int w = 0; w < NW; w++)
        if (wk_valid_o[w]) wtag_q[w] <= iss_tag[w];
      if (loop_pop)             lp_next_q <= '0;
      else if (!gang_on_q)      lp_next_q <= lp_next_q + loop_cnt;
      if (gang_start) begin
        gang_on_q   <= 1'b1;
        gang_part_q <= 3'd1;
      end else if (gang_on_q && gang_part_q < 3'(NW)) begin
        gang_part_q <= gang_part_q + 3'd1;
      end else if (gang_on_q && busy_q == '0) begin
        gang_on_q   <= 1'b0;
        gang_part_q <= '0;
      end
    end
  end

  // ---------------- side channel ----------------
  logic [2:0]       side_v_q;
  logic [TID_W-1:0] side_tid_q;
  logic [PW-1:0]    side_pay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_v_q   <= '0;
      side_tid_q <= '0;
      side_pay_q <= '0;
    end else begin
      side_v_q <= {acc && in_kind_i == K_REG, acc && in_kind_i == K_SPEC,
                   acc && in_kind_i == K_MEM};
      if (acc) begin
        side_tid_q <= in_tid_i;
        side_pay_q <= in_payload_i;
      end
    end
  end

  assign side_valid_o   = side_v_q;
  assign side_tid_o     = side_tid_q;
  assign side_payload_o = side_pay_q;
endmodule

// File: rtl/frag_dispatch_chk.sv
module frag_dispatch_chk
  import frag_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_i,
  input logic [2:0]    in_kind_i,
  input logic [NW-1:0] wk_valid_i,
  input logic [2:0]    side_valid_i,
  input logic [NW-1:0] busy_i,
  input logic          gang_on_i
);
  // R4
  max_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wk_valid_i) <= MAX_ISSUE);

  // R3
  idle_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wk_valid_i & busy_i) == '0);

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wk_valid_i[0] |=> busy_i[0]);

  // R1
  side_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(side_valid_i));

  // R1
  side_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_i && in_kind_i == K_MEM) |=> side_valid_i[0]);

  // R7
  gang_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gang_on_i |-> $countones(wk_valid_i) <= 1);

  // R10
  bad_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_kind_i > 3'd5) |=> side_valid_i == '0);
endmodule

bind frag_dispatch frag_dispatch_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_i   (in_ready_o),
  .in_kind_i    (in_kind_i),
  .wk_valid_i   (wk_valid_o),
  .side_valid_i (side_valid_o),
  .busy_i       (busy_q),
  .gang_on_i    (gang_on_q)
);

// File: tb/frag_dispatch_tb.sv
module frag_dispatch_tb;
  localparam int CLK_P  = 10;
  localparam int PW     = 16;
  localparam int TID_W  = 3;
  localparam int TAG_W  = 4;
  localparam int ITER_W = 4;

  logic                        clk_i = 1'b0;
  logic                        rst_ni = 1'b0;
  logic                        in_valid_i = 1'b0;
  logic                        in_ready_o;
  logic [2:0]                  in_kind_i = '0;
  logic [TID_W-1:0]            in_tid_i = '0;
  logic [TAG_W-1:0]            in_tag_i = '0;
  logic [TAG_W-1:0]            in_dep_i = '0;
  logic [ITER_W-1:0]           in_iters_i = '0;
  logic                        in_gang_i = 1'b0;
  logic [PW-1:0]               in_payload_i = '0;
  logic [3:0]                  done_i = '0;
  logic [3:0]                  wk_valid_o;
  logic [3:0][TID_W-1:0]       wk_tid_o;
  logic [3:0][ITER_W-1:0]      wk_iter_o;
  logic [3:0][PW-1:0]          wk_payload_o;
  logic [2:0]                  side_valid_o;
  logic [TID_W-1:0]            side_tid_o;
  logic [PW-1:0]               side_payload_o;

  frag_dispatch u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  typedef struct {
    int kind; int tid; int tag; int dep; int iters; int gang; int pay;
  } fr_t;

  int tests = 0, fails = 0;
  fr_t fq[$], lq[$], dq[$];
  int busy[4], wtg[4], rem[16];
  int lp_next = 0, gang_on = 0, gang_part = 0;
  int s_v = 0, s_tid = 0, s_pay = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic fr_t mk(int kind, int tag, int dep, int iters, int gang, int pay);
    fr_t f;
    f.kind = kind; f.tid = tag % 8; f.tag = tag; f.dep = dep;
    f.iters = iters; f.gang = gang; f.pay = pay;
    return f;
  endfunction

  task automatic step(input bit v, input fr_t f, input int dmask);
    int src[4], eit[4], epay[4], etid[4], etag[4];
    int exp_rdy, n, dtk, ftk, lcnt, left, dok, allidle;
    string rq;
    @(negedge clk_i);
    in_valid_i = v; in_kind_i = f.kind[2:0]; in_tid_i = f.tid[TID_W-1:0];
    in_tag_i = f.tag[TAG_W-1:0]; in_dep_i = f.dep[TAG_W-1:0];
    in_iters_i = f.iters[ITER_W-1:0]; in_gang_i = f.gang[0];
    in_payload_i = f.pay[PW-1:0]; done_i = dmask[3:0];
    #1;
    exp_rdy = (f.kind == 1) ? int'(fq.size() < 8) : (f.kind == 2) ? int'(lq.size() < 8) :
              (f.kind == 3) ? int'(dq.size() < 8) : 1;
    check(in_ready_o == exp_rdy[0], "R2 ready", int'(in_ready_o), exp_rdy);
    check(side_valid_o == s_v[2:0], "R1 side valid", int'(side_valid_o), s_v);
    if (s_v != 0) begin
      check(side_payload_o == s_pay[PW-1:0], "R1 side payload", int'(side_payload_o), s_pay);
      check(side_tid_o == s_tid[TID_W-1:0], "R1 side thread", int'(side_tid_o), s_tid);
    end
    // expected issue
    allidle = int'(busy[0] == 0 && busy[1] == 0 && busy[2] == 0 && busy[3] == 0);
    for (int w = 0; w < 4; w++) begin src[w] = 0; eit[w] = 0; epay[w] = 0; etid[w] = 0; etag[w] = 0; end
    n = 0; dtk = 0; ftk = 0; lcnt = 0;
    left = (lq.size() > 0) ? lq[0].iters + 1 - lp_next : 0;
    dok  = int'(dq.size() > 0) && (dq.size() > 0 ? rem[dq[0].dep] == 0 : 0);
    if (gang_on != 0) begin
      if (gang_part < 4) begin src[gang_part] = 4; eit[gang_part] = gang_part; end
    end else if (lq.size() > 0 && lq[0].gang != 0) begin
      if (allidle != 0) src[0] = 4;
    end else begin
      for (int w = 0; w < 4; w++) begin
        if (busy[w] == 0 && n < 3) begin
          if (dok != 0 && dtk == 0) begin src[w] = 1; dtk = 1; n++; end
          else if (lcnt < left) begin src[w] = 2; eit[w] = lp_next + lcnt; lcnt++; n++; end
          else if (fq.size() > 0 && ftk == 0) begin src[w] = 3; ftk = 1; n++; end
        end
      end
    end
    for (int w = 0; w < 4; w++) begin
      case (src[w])
        1: begin epay[w] = dq[0].pay; etid[w] = dq[0].tid; etag[w] = dq[0].tag; end
        2, 4: begin epay[w] = lq[0].pay; etid[w] = lq[0].tid; etag[w] = lq[0].tag; end
        3: begin epay[w] = fq[0].pay; etid[w] = fq[0].tid; etag[w] = fq[0].tag; end
        default: ;
      endcase
      rq = (src[w] == 1) ? "R5 depend" : (src[w] == 2) ? "R6 loop" :
           (src[w] == 3) ? "R8 free" : (src[w] == 4) ? "R7 gang" : "R3 idle/R4 cap";
      check(wk_valid_o[w] == (src[w] != 0), rq, int'(wk_valid_o[w]), int'(src[w] != 0));
      if (src[w] != 0) begin
        check(wk_payload_o[w] == epay[w][PW-1:0], rq, int'(wk_payload_o[w]), epay[w]);
        check(wk_tid_o[w] == etid[w][TID_W-1:0], rq, int'(wk_tid_o[w]), etid[w]);
        check(wk_iter_o[w] == eit[w][ITER_W-1:0], rq, int'(wk_iter_o[w]), eit[w]);
      end
    end
    // model update
    for (int w = 0; w < 4; w++)
      if (dmask[w] && busy[w] != 0) begin busy[w] = 0; rem[wtg[w]]--; end
    for (int w = 0; w < 4; w++)
      if (src[w] != 0) begin busy[w] = 1; wtg[w] = etag[w]; end
    if (dtk != 0) void'(dq.pop_front());
    if (ftk != 0) void'(fq.pop_front());
    if (gang_on == 0 && src[0] == 4) begin
      gang_on = 1; gang_part = 1;
    end else if (gang_on != 0 && gang_part < 4) begin
      if (gang_part == 3) void'(lq.pop_front());
      gang_part++;
    end else if (gang_on != 0 && allidle != 0) begin
      gang_on = 0; gang_part = 0;
    end
    if (lcnt > 0) begin
      if (lcnt == left) begin void'(lq.pop_front()); lp_next = 0; end
      else lp_next += lcnt;
    end
    s_v = 0;
    if (v && exp_rdy != 0) begin
      case (f.kind)
        0: s_v = 1;
        4: s_v = 2;
        5: s_v = 4;
        1: fq.push_back(f);
        2: lq.push_back(f);
        3: dq.push_back(f);
        default: ;
      endcase
      if (f.kind >= 1 && f.kind <= 3)
        rem[f.tag] = (f.kind == 2) ? ((f.gang != 0) ? 4 : f.iters + 1) : 1;
      s_tid = f.tid; s_pay = f.pay;
    end
  endtask

  fr_t nil;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, nil, 0);
  endtask

  task automatic send(input fr_t f);
    step(1'b1, f, 0);
  endtask

  task automatic fin(input int m);
    step(1'b0, nil, m);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, nil, busy[0] | (busy[1] << 1) | (busy[2] << 2) | (busy[3] << 3));
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    nil = mk(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin busy[i] = 0; wtg[i] = 0; end
    for (int i = 0; i < 16; i++) rem[i] = 0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(wk_valid_o == '0, "R9 reset workers", int'(wk_valid_o), 0);
    check(side_valid_o == '0, "R9 reset side", int'(side_valid_o), 0);
    check(in_ready_o == 1'b1, "R9 reset ready", int'(in_ready_o), 1);
    rst_ni = 1'b1;
    idle(2);
    // R1 side kinds, R10 unused kinds
    send(mk(0, 0, 0, 0, 0, 16'h1100));
    send(mk(4, 1, 0, 0, 0, 16'h4400));
    send(mk(5, 2, 0, 0, 0, 16'h5500));
    send(mk(6, 3, 0, 0, 0, 16'h6600));
    send(mk(7, 4, 0, 0, 0, 16'h7700));
    idle(2);
    // R6/R4 six-iteration loop on idle pool, R5/R8 depend + free behind it
    send(mk(2, 6, 0, 5, 0, 16'h2006));
    send(mk(3, 7, 6, 0, 0, 16'h3007));
    send(mk(1, 8, 0, 0, 0, 16'h1008));
    fin(4'b0001);
    fin(4'b0110);
    idle(1);
    fin(4'b1001);
    idle(1);
    drain(3);
    idle(2);
    fin(4'b1111); // R3 stray completions on idle workers
    idle(2);
    // R7 gang with busy workers and a waiting free fragment
    send(mk(1, 1, 0, 0, 0, 16'h1101));
    send(mk(1, 2, 0, 0, 0, 16'h1102));
    send(mk(2, 9, 0, 7, 1, 16'h2909));
    send(mk(1, 10, 0, 0, 0, 16'h110a));
    fin(4'b0001);
    idle(1);
    fin(4'b0010);
    idle(5);
    fin(4'b0011);
    fin(4'b1100);
    idle(3);
    drain(3);
    // R2 full free queue while all workers busy
    for (int i = 0; i < 4; i++) send(mk(1, 11 + i, 0, 0, 0, 16'h1200 + i));
    idle(1);
    for (int i = 0; i < 9; i++) send(mk(1, 1 + i, 0, 0, 0, 16'h1300 + i));
    send(mk(1, 15, 0, 0, 0, 16'h13ff));
    drain(12);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule